// File: doc/BRIEF.md
# Half-Duplex Collision Retry Controller

This block sits beside the transmit path of a half-duplex Ethernet MAC. It decides whether a frame is retried after a collision, and when. The transmit path reports three events: the start of a frame, a collision, and successful completion. The block answers with a one-cycle retransmit request once a random back-off wait has ended. If the frame cannot be sent, it answers instead with a one-cycle abort carrying exactly one cause flag.

The back-off wait is r slot times, with r drawn uniformly from [0, 2^k). Here k is the retransmission number, capped by a two-bit limit setting. A single-attempt mode aborts on the first collision. A deferral watchdog aborts a frame that has been held off by carrier deferral for too long. In full-duplex operation the block ignores collisions and deferral, so no back-off or abort ever starts.

All pins are plain control and status levels or pulses. There is no data stream, so no valid/ready handshake applies.

Top module: `hdr_retry_ctrl`

## Requirements
- R1: After reset, the outputs `retx_req_o`, `backoff_busy_o`, `abort_o`, `abort_excess_col_o` and `abort_excess_defer_o` are all 0, and the block waits for a frame start.
- R2: Collision with retries allowed:
  - A collision during an attempt raises `backoff_busy_o` in the next cycle.
  - The wait ends with `retx_req_o` high for one cycle. At that cycle exactly r·SLOT_BITS bit ticks have been counted since the wait began, where r is an integer and 0 ≤ r < 2^k.
  - `backoff_busy_o` drops in the following cycle.
- R3: k = min(n, L). n is the number of the retransmission (1 for the first retry). L depends on `bo_limit_i`: 0 gives 10, 1 gives 8, 2 gives 4 and 3 gives 1.
- R4: The back-off wait advances only on cycles with `bit_tick_i` high. A drawn value of zero gives the retransmit request in the first wait cycle. `retx_req_o` is never high outside a wait.
- R5: With `retry_dis_i` high, a collision aborts the frame one cycle later with `abort_excess_col_o` set, and no wait starts.
- R6: Counting the first transmission, the 16th collision of a frame aborts it with `abort_excess_col_o` set, instead of starting a 16th wait.
- R7: Deferral watchdog:
  - While `defer_chk_en_i` is high and a frame is pending, each bit tick with `deferring_i` high is counted.
  - The tick that takes the count above DEFER_LIMIT aborts the frame one cycle later with `abort_excess_defer_o` set.
  - The count is cleared only at frame start.
  - With the check disabled, no deferral abort occurs.
- R8: While `full_duplex_i` is high, collisions and deferral are ignored: no wait, no retransmit request and no abort is produced.
- R9: Frame start is accepted only when no frame is pending. Collisions are acted on only during an attempt. Frame done ends the frame only during an attempt.
- R10: `abort_o` is a one-cycle pulse. While it is high exactly one of the two cause flags is set, and both flags are 0 otherwise. A deferral abort takes priority over frame done and collision in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex_i | input | 1 | High in full-duplex operation; the block stays passive |
| frame_start_i | input | 1 | Pulse: first transmission of a new frame begins |
| frame_done_i | input | 1 | Pulse: the current attempt completed without collision |
| collision_i | input | 1 | Pulse: collision seen during the current attempt |
| bit_tick_i | input | 1 | One pulse per bit time |
| bo_limit_i | input | 2 | Back-off exponent cap select (0:10, 1:8, 2:4, 3:1) |
| retry_dis_i | input | 1 | High: single attempt, no retry |
| defer_chk_en_i | input | 1 | High: deferral watchdog enabled |
| deferring_i | input | 1 | High while the transmitter is held off by carrier |
| retx_req_o | output | 1 | Pulse: start the retransmission now |
| backoff_busy_o | output | 1 | High during the back-off wait |
| abort_o | output | 1 | Pulse: frame abandoned |
| abort_excess_col_o | output | 1 | With abort_o: too many collisions or retry disabled |
| abort_excess_defer_o | output | 1 | With abort_o: deferral exceeded the limit |

## Verification
The assertions check four things on every cycle. The back-off counter moves only by one step on a tick. The attempt and deferral counts stay within their bounds. Abort pulses are single-cycle and carry one cause. Single-attempt mode and full-duplex mode never enter a wait.

Other behaviours can only be shown by the bench scenarios: the drawn wait length being a whole number of slots inside the cap for each limit code, the abort on the 16th collision, the exact tick on which the deferral watchdog fires, and deferral counts surviving a rejected frame start. A behavioural model checks these on every clock.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  localparam int unsigned EXP_MAX = 10;
  localparam int unsigned EXP_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_BACKOFF = 2'd2
  } hdr_state_e;

  typedef struct packed {
    logic valid;
    logic ex_col;
    logic ex_defer;
  } hdr_abort_t;

  function automatic logic [EXP_W-1:0] exp_cap(input logic [1:0] code);
    logic [EXP_W-1:0] cap;
    unique case (code)
      2'd0:    cap = EXP_W'(10);
      2'd1:    cap = EXP_W'(8);
      2'd2:    cap = EXP_W'(4);
      default: cap = EXP_W'(1);
    endcase
    return cap;
  endfunction
endpackage

// File: rtl/hdr_lfsr.sv
module hdr_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] rnd_o
);
  logic [W-1:0] q;
  logic [W-1:0] nxt;

  always_comb begin
    nxt = {1'b0, q[W-1:1]};
    if (q[0]) nxt = nxt ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= nxt;
  end

  assign rnd_o = q;

  // R2: the random source never locks up in the all-zero state
  a_r2_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);
endmodule

// File: rtl/hdr_backoff_timer.sv
module hdr_backoff_timer #(
  parameter int unsigned CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R4: without a tick the remaining wait is frozen
  a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(cnt_q));
  // R4: a tick shortens the wait by exactly one bit time
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/hdr_defer_watch.sv
module hdr_defer_watch #(
  parameter int unsigned LIMIT = 24288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic count_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign fire_o = count_i && (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (count_i && !fire_o) cnt_q <= cnt_q + CW'(1);
  end

  // R7: the deferral count never passes the limit
  a_r7_defer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));
  // R7: the count moves only while deferral ticks are counted or on clear
  a_r7_defer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hdr_retry_ctrl.sv
module hdr_retry_ctrl
  import hdr_pkg::*;
#(
  parameter int unsigned SLOT_BITS    = 512,
  parameter int unsigned DEFER_LIMIT  = 24288,
  parameter int unsigned MAX_ATTEMPTS = 16,
  parameter int unsigned RND_W        = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       full_duplex_i,
  input  logic       frame_start_i,
  input  logic       frame_done_i,
  input  logic       collision_i,
  input  logic       bit_tick_i,
  input  logic [1:0] bo_limit_i,
  input  logic       retry_dis_i,
  input  logic       defer_chk_en_i,
  input  logic       deferring_i,
  output logic       retx_req_o,
  output logic       backoff_busy_o,
  output logic       abort_o,
  output logic       abort_excess_col_o,
  output logic       abort_excess_defer_o
);
  localparam int unsigned AW = $clog2(MAX_ATTEMPTS + 1);
  localparam int unsigned CW = $clog2(SLOT_BITS + 1) + EXP_MAX;

  hdr_state_e       state_q;
  logic [AW-1:0]    att_q;
  hdr_abort_t       abort_q;

  logic [RND_W-1:0] rnd;
  logic [EXP_MAX-1:0] rnd_fold;
  logic [EXP_MAX-1:0] mask;
  logic [EXP_MAX-1:0] r_val;
  logic [EXP_W-1:0] cap;
  logic [EXP_W-1:0] k_sel;
  logic [CW-1:0]    wait_len;
  logic             collide, give_up, start_wait, bo_zero;
  logic             pending, defer_count, defer_clear, defer_fire;

  hdr_lfsr #(.W(RND_W)) u_rnd (
    .clk   (clk),
    .rst_n (rst_n),
    .rnd_o (rnd)
  );

  // fold the whole random word into the exponent-wide draw
  assign rnd_fold = rnd[EXP_MAX-1:0] ^ EXP_MAX'(rnd >> EXP_MAX);

  assign cap   = exp_cap(bo_limit_i);
  assign k_sel = (att_q >= AW'(cap)) ? cap : EXP_W'(att_q);

  for (genvar i = 0; i < EXP_MAX; i++) begin : g_mask
    assign mask[i] = (EXP_W'(i) < k_sel);
  end

  assign r_val    = rnd_fold & mask;
  assign wait_len = CW'(r_val) * CW'(SLOT_BITS);

  assign pending     = (state_q != ST_IDLE);
  assign collide     = (state_q == ST_ACTIVE) && collision_i && !full_duplex_i;
  assign give_up     = retry_dis_i || (att_q >= AW'(MAX_ATTEMPTS));
  assign defer_count = pending && !full_duplex_i && defer_chk_en_i &&
                       deferring_i && bit_tick_i;
  assign defer_clear = (state_q == ST_IDLE) && frame_start_i;
  assign start_wait  = collide && !give_up && !frame_done_i && !defer_fire;

  hdr_backoff_timer #(.CW(CW)) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_wait),
    .load_val_i (wait_len),
    .tick_i     (bit_tick_i),
    .zero_o     (bo_zero)
  );

  hdr_defer_watch #(.LIMIT(DEFER_LIMIT)) u_defer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (defer_clear),
    .count_i (defer_count),
    .fire_o  (defer_fire)
  );

  assign retx_req_o = (state_q == ST_BACKOFF) && bo_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      att_q   <= '0;
      abort_q <= '0;
    end else begin
      abort_q <= '0;
      if (defer_fire) begin
        state_q <= ST_IDLE;
        abort_q <= '{valid: 1'b1, ex_col: 1'b0, ex_defer: 1'b1};
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (frame_start_i) begin
              state_q <= ST_ACTIVE;
              att_q   <= AW'(1);
            end
          end
          ST_ACTIVE: begin
            if (frame_done_i) begin
              state_q <= ST_IDLE;
            end else if (collide) begin
              if (give_up) begin
                state_q <= ST_IDLE;
                abort_q <= '{valid: 1'b1, ex_col: 1'b1, ex_defer: 1'b0};
              end else begin
                state_q <= ST_BACKOFF;
                att_q   <= att_q + AW'(1);
              end
            end
          end
          ST_BACKOFF: begin
            if (bo_zero) state_q <= ST_ACTIVE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign backoff_busy_o       = (state_q == ST_BACKOFF);
  assign abort_o              = abort_q.valid;
  assign abort_excess_col_o   = abort_q.ex_col;
  assign abort_excess_defer_o = abort_q.ex_defer;

  // R10: abort is a single-cycle pulse
  a_r10_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);
  // R10: exactly one cause accompanies an abort
  a_r10_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $onehot({abort_excess_col_o, abort_excess_defer_o}));
  // R10: cause flags are quiet without an abort
  a_r10_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_o |-> !(abort_excess_col_o || abort_excess_defer_o));
  // R6: the attempt count never passes the maximum
  a_r6_attempt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    att_q <= AW'(MAX_ATTEMPTS));
  // R5: single-attempt mode never enters a wait
  a_r5_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_dis_i && state_q == ST_ACTIVE) |=> !$rose(backoff_busy_o));
  // R8: full duplex never enters a wait
  a_r8_fd_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex_i && state_q == ST_ACTIVE) |=> !$rose(backoff_busy_o));
  // R2: a retransmit request ends the wait
  a_r2_retx_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
    retx_req_o |=> !backoff_busy_o);
endmodule

// File: tb/hdr_retry_ctrl_tb_top.sv
module hdr_retry_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT  = 8;
  localparam int LIMIT = 40;
  localparam int MAXA  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic full_duplex = 0, frame_start = 0, frame_done = 0, collision = 0;
  logic bit_tick = 0, retry_dis = 0, defer_chk = 0, deferring = 0;
  logic [1:0] bo_limit = 2'd3;
  logic retx_req_o, backoff_busy_o, abort_o, abort_excess_col_o, abort_excess_defer_o;

  int total = 0, bad = 0, cyc = 0, tick_div = 1;
  int n_retx = 0, n_ab_col = 0, n_ab_def = 0;
  int max_r[4];
  bit seen_r1_code3 = 0;

  // behavioural reference state
  int m_mode = 0, m_att = 0, m_defer = 0, m_elapsed = 0, m_k = 0, m_code = 0;
  bit m_ab = 0, m_col = 0, m_def = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_retry_ctrl #(.SLOT_BITS(SLOT), .DEFER_LIMIT(LIMIT), .MAX_ATTEMPTS(MAXA)) dut_i (
    .clk(clk), .rst_n(rst_n), .full_duplex_i(full_duplex), .frame_start_i(frame_start),
    .frame_done_i(frame_done), .collision_i(collision), .bit_tick_i(bit_tick),
    .bo_limit_i(bo_limit), .retry_dis_i(retry_dis), .defer_chk_en_i(defer_chk),
    .deferring_i(deferring), .retx_req_o(retx_req_o), .backoff_busy_o(backoff_busy_o),
    .abort_o(abort_o), .abort_excess_col_o(abort_excess_col_o),
    .abort_excess_defer_o(abort_excess_defer_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // bit tick generator
  always @(posedge clk) begin
    #1;
    cyc++;
    bit_tick = (cyc % tick_div == 0);
  end

  function automatic int cap_of(input int code);
    case (code)
      0: return 10;
      1: return 8;
      2: return 4;
      default: return 1;
    endcase
  endfunction

  // reference model, compared every clock at the falling edge
  always @(negedge clk) begin
    bit n_ab, n_col, n_def, fire;
    int bound;
    if (!rst_n) begin
      m_mode = 0; m_att = 0; m_defer = 0; m_ab = 0; m_col = 0; m_def = 0;
    end else begin
      chk(backoff_busy_o == (m_mode == 2), "R2 busy", backoff_busy_o, m_mode == 2);
      chk(abort_o == m_ab, "R10 abort", abort_o, m_ab);
      chk(abort_excess_col_o == m_col, "R6 col flag", abort_excess_col_o, m_col);
      chk(abort_excess_defer_o == m_def, "R7 defer flag", abort_excess_defer_o, m_def);
      if (abort_o && abort_excess_col_o) n_ab_col++;
      if (abort_o && abort_excess_defer_o) n_ab_def++;
      if (retx_req_o) n_retx++;
      if (m_mode != 2) chk(!retx_req_o, "R4 retx outside wait", retx_req_o, 0);
      n_ab = 0; n_col = 0; n_def = 0; fire = 0;
      if (m_mode != 0 && !full_duplex && defer_chk && deferring && bit_tick) begin
        m_defer++;
        if (m_defer > LIMIT) fire = 1;
      end
      if (m_mode == 2) begin
        bound = ((1 << m_k) - 1) * SLOT;
        if (retx_req_o) begin
          chk((m_elapsed % SLOT == 0) && (m_elapsed <= bound), "R3 wait length",
              m_elapsed, bound);
          if (m_elapsed / SLOT > max_r[m_code]) max_r[m_code] = m_elapsed / SLOT;
          if (m_code == 3 && m_elapsed == SLOT) seen_r1_code3 = 1;
        end else begin
          chk(m_elapsed < bound, "R2 wait overrun", m_elapsed, bound);
        end
      end
      if (fire) begin
        m_mode = 0; n_ab = 1; n_def = 1;
      end else begin
        case (m_mode)
          0: if (frame_start) begin m_mode = 1; m_att = 1; m_defer = 0; end
          1: begin
            if (frame_done) m_mode = 0;
            else if (collision && !full_duplex) begin
              if (retry_dis || m_att >= MAXA) begin
                m_mode = 0; n_ab = 1; n_col = 1;
              end else begin
                m_code = bo_limit;
                m_k = (m_att < cap_of(bo_limit)) ? m_att : cap_of(bo_limit);
                m_att++; m_mode = 2; m_elapsed = 0;
              end
            end
          end
          default: begin
            if (retx_req_o) m_mode = 1;
            else if (bit_tick) m_elapsed++;
          end
        endcase
      end
      m_ab = n_ab; m_col = n_col; m_def = n_def;
    end
  end

  task automatic p_start(); @(posedge clk); #1 frame_start = 1; @(posedge clk); #1 frame_start = 0; endtask
  task automatic p_done();  @(posedge clk); #1 frame_done = 1;  @(posedge clk); #1 frame_done = 0;  endtask
  task automatic p_col();   @(posedge clk); #1 collision = 1;   @(posedge clk); #1 collision = 0;   endtask
  task automatic wait_retx();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (retx_req_o) break;
    end
  endtask
  task automatic defer_n(input int n);
    @(posedge clk); #1 deferring = 1;
    repeat (n) @(posedge clk);
    #1 deferring = 0;
  endtask
  task automatic frame_with_cols(input int ncol);
    p_start();
    for (int i = 0; i < ncol; i++) begin p_col(); wait_retx(); end
    p_done();
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b0, b1, b2;
    for (int i = 0; i < 4; i++) max_r[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!retx_req_o && !backoff_busy_o && !abort_o && !abort_excess_col_o &&
        !abort_excess_defer_o, "R1 reset outputs", {retx_req_o, backoff_busy_o, abort_o}, 0);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);

    // R2 / R3 code 3: single-slot cap
    bo_limit = 2'd3; b0 = n_retx;
    for (int i = 0; i < 20; i++) frame_with_cols(1);
    chk(n_retx - b0 == 20, "R2 retries granted", n_retx - b0, 20);
    chk(max_r[3] <= 1, "R3 cap 1", max_r[3], 1);
    chk(seen_r1_code3, "R3 nonzero draw seen", seen_r1_code3, 1);

    // R3 code 2: exponent up to 4
    bo_limit = 2'd2;
    for (int i = 0; i < 4; i++) frame_with_cols(5);
    chk(max_r[2] >= 2 && max_r[2] <= 15, "R3 cap 4", max_r[2], 15);
    bo_limit = 2'd1; frame_with_cols(9);
    chk(max_r[1] <= 255, "R3 cap 8", max_r[1], 255);
    bo_limit = 2'd0; frame_with_cols(11);
    chk(max_r[0] <= 1023, "R3 cap 10", max_r[0], 1023);

    // R4 sparse ticks
    tick_div = 3; bo_limit = 2'd2; b0 = n_retx;
    frame_with_cols(4);
    chk(n_retx - b0 == 4, "R4 sparse ticks retries", n_retx - b0, 4);
    tick_div = 1;

    // R5 retry disabled
    retry_dis = 1; b0 = n_ab_col; b1 = n_retx;
    p_start(); p_col(); repeat (3) @(posedge clk);
    chk(n_ab_col - b0 == 1, "R5 single attempt abort", n_ab_col - b0, 1);
    chk(n_retx == b1, "R5 no retry", n_retx - b1, 0);
    retry_dis = 0;

    // R6 sixteen attempts
    bo_limit = 2'd3; b0 = n_ab_col; b1 = n_retx;
    p_start();
    for (int i = 0; i < 15; i++) begin p_col(); wait_retx(); end
    p_col(); repeat (3) @(posedge clk);
    chk(n_ab_col - b0 == 1, "R6 abort on 16th collision", n_ab_col - b0, 1);
    chk(n_retx - b1 == 15, "R6 fifteen retries", n_retx - b1, 15);

    // R7 deferral watchdog
    defer_chk = 1; b0 = n_ab_def;
    p_start(); defer_n(LIMIT + 5); repeat (3) @(posedge clk);
    chk(n_ab_def - b0 == 1, "R7 deferral abort", n_ab_def - b0, 1);
    b0 = n_ab_def;
    p_start(); defer_n(LIMIT); repeat (2) @(posedge clk);
    chk(n_ab_def == b0, "R7 exactly limit no abort", n_ab_def - b0, 0);
    p_done();
    p_start(); defer_n(30); p_done(); p_start(); defer_n(30); p_done();
    chk(n_ab_def == b0, "R7 cleared at frame start", n_ab_def - b0, 0);
    defer_chk = 0;
    p_start(); defer_n(100); p_done();
    chk(n_ab_def == b0, "R7 disabled no abort", n_ab_def - b0, 0);

    // R8 full duplex
    full_duplex = 1; defer_chk = 1; b0 = n_retx; b1 = n_ab_col; b2 = n_ab_def;
    p_start(); p_col(); repeat (3) @(posedge clk);
    chk(!backoff_busy_o && n_retx == b0, "R8 collision ignored", backoff_busy_o, 0);
    defer_n(LIMIT + 10); p_done();
    chk(n_ab_col == b1 && n_ab_def == b2, "R8 no abort", n_ab_col + n_ab_def, b1 + b2);
    full_duplex = 0;

    // R9 events outside their state
    b0 = n_retx; b1 = n_ab_col;
    p_col(); repeat (3) @(posedge clk);
    chk(!backoff_busy_o && n_retx == b0 && n_ab_col == b1, "R9 idle collision ignored",
        backoff_busy_o, 0);
    b2 = n_ab_def;
    p_start(); defer_n(30); p_start(); defer_n(15); repeat (3) @(posedge clk);
    chk(n_ab_def - b2 == 1, "R9 restart ignored keeps deferral", n_ab_def - b2, 1);
    defer_chk = 0;
    repeat (5) @(posedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule